// File: doc/BRIEF.md
# Stage-2 Translation Table Base Address Former

This block turns the 64-bit stage-2 base register image into the 52-bit physical address of the first-level translation table. It also reports an address-size fault when the packed wide layout is used on hardware without 52-bit physical address support. It supports two layouts. In the wide layout, selected by a physical-size code of 0b110 together with the 64KB granule, register bits [5:2] carry address bits [51:48] and the alignment point is never below bit 6. In the plain layout, the upper four address bits are zero and the register supplies bits [47:x].

A walker drives the register image, the size code, the granule flag, the alignment exponent x and the support flag, then pulses `start`. One cycle later the registered results appear, and they stay unchanged until the next pulse. When a reserved-zero bit is set, the block forces that address bit to zero and raises a warning. An exponent outside 1..47 gives a zero address and raises an error flag.

Top module: `s2_base_former`

## Requirements
- R1: After reset, `baseAddr`, `sizeFault`, `misalignWarn` and `rangeErr` are all zero.
- R2: Results are captured on the clock edge where `start` is high and appear one cycle later. Without `start`, all outputs hold their values whatever the inputs do.
- R3: In the plain layout, `baseAddr[47:x]` equals `regVal[47:x]`, `baseAddr[x-1:0]` is zero, and `baseAddr[51:48]` is zero.
- R4: In the wide layout with x >= 6, `baseAddr[47:x]` equals `regVal[47:x]` and `baseAddr[51:48]` equals `regVal[5:2]`.
- R5: In the wide layout with x < 6, alignment is taken at bit 6: `baseAddr[5:0]` is zero and `baseAddr[47:6]` equals `regVal[47:6]`.
- R6: `sizeFault` is set when all of the following hold: `psField` is 3'b110, `gran64k` is 1, `pa52Sup` is 0, and `regVal[5:2]` is nonzero. This is independent of x.
- R7: `sizeFault` stays low when `pa52Sup` is 1.
- R8: In the plain layout, `misalignWarn` is set when any of `regVal[x-1:1]` is 1.
- R9: In the wide layout, `misalignWarn` is set when `regVal[1]` is 1, or when x > 6 and any of `regVal[x-1:6]` is 1.
- R10: `regVal[0]` and `regVal[63:48]` never affect any output.
- R11: When x is 0 or greater than 47, `rangeErr` is 1, `baseAddr` is zero and `misalignWarn` is 0.
- R12: The wide layout is used only when `psField` is 3'b110 and `gran64k` is 1. With a size code of 3'b110 and a smaller granule, the plain layout applies and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture strobe |
| regVal | input | 64 | Stage-2 base register image |
| psField | input | 3 | Physical-size code |
| gran64k | input | 1 | 64KB granule in use |
| alignExp | input | 6 | Alignment exponent x |
| pa52Sup | input | 1 | Hardware supports 52-bit PAs |
| baseAddr | output | 52 | Formed table base address |
| sizeFault | output | 1 | Address-size fault |
| misalignWarn | output | 1 | A reserved-zero bit was set |
| rangeErr | output | 1 | Exponent outside 1..47 |

## Verification
The hardest case to reach is the narrow-exponent wide layout. There, bits [5:2] are address bits, bits below 6 must still be cleared, and no reserved range above bit 6 exists. A register image with every low bit set except bit 1, paired with x = 4, hits this case directly. Paired cases with x = 6 and x = 10 cover both edges of the reserved window. A size code of 0b110 with the small granule, plus a nonzero nibble, checks that the wide path is not entered by the size code alone.

// File: rtl/s2base_pkg.sv
package s2base_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture this cycle
    logic wide;      // packed 52-bit layout selected
    logic rangeBad;  // exponent outside legal window
  } ctlStrobes_t;
endpackage

// File: rtl/s2base_ctrl.sv
module s2base_ctrl
  import s2base_pkg::*;
#(
  parameter int X_W   = 6,
  parameter int PS_W  = 3,
  parameter int X_MIN = 1,
  parameter int X_MAX = 47,
  parameter logic [PS_W-1:0] WIDE_PS = 3'b110
) (
  input  logic            start,
  input  logic [PS_W-1:0] psField,
  input  logic            gran64k,
  input  logic [X_W-1:0]  alignExp,
  output ctlStrobes_t     ctl
);
  always_comb begin
    ctl.load     = start;
    ctl.wide     = (psField == WIDE_PS) && gran64k;
    ctl.rangeBad = (int'(alignExp) < X_MIN) || (int'(alignExp) > X_MAX);
  end
endmodule

// File: rtl/s2base_dpath.sv
module s2base_dpath
  import s2base_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int PA_W    = 52,
  parameter int OA_W    = 48,
  parameter int X_W     = 6,
  parameter int Z_FLOOR = 6,
  parameter int HI_LSB  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [REG_W-1:0]  regVal,
  input  logic [X_W-1:0]    alignExp,
  input  logic              pa52Sup,
  output logic [PA_W-1:0]   baseAddr,
  output logic              sizeFault,
  output logic              misalignWarn,
  output logic              rangeErr
);
  localparam int HI_W = PA_W - OA_W;

  logic [OA_W-1:0] xMask, zMask, floorMask, lowBody;
  logic [X_W-1:0]  zExp;
  logic [HI_W-1:0] hiNib;
  logic [PA_W-1:0] addrNext;
  logic            resvNext, faultNext;
  logic            unusedBits;

  assign unusedBits = ^{regVal[REG_W-1:OA_W], regVal[0]};
  assign lowBody    = regVal[OA_W-1:0];
  assign hiNib      = regVal[HI_LSB+HI_W-1:HI_LSB];

  always_comb begin
    zExp      = (int'(alignExp) < Z_FLOOR) ? X_W'(Z_FLOOR) : alignExp;
    xMask     = (OA_W'(1) << alignExp) - OA_W'(1);
    zMask     = (OA_W'(1) << zExp) - OA_W'(1);
    floorMask = (OA_W'(1) << Z_FLOOR) - OA_W'(1);
    faultNext = ctl.wide && !pa52Sup && (hiNib != '0);
    if (ctl.rangeBad) begin
      addrNext = '0;
      resvNext = 1'b0;
    end else if (ctl.wide) begin
      addrNext = {hiNib, lowBody & ~zMask};
      resvNext = regVal[1] | (|(lowBody & xMask & ~floorMask));
    end else begin
      addrNext = {{HI_W{1'b0}}, lowBody & ~xMask};
      resvNext = |(lowBody & xMask & ~OA_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr     <= '0;
      sizeFault    <= 1'b0;
      misalignWarn <= 1'b0;
      rangeErr     <= 1'b0;
    end else if (ctl.load) begin
      baseAddr     <= addrNext;
      sizeFault    <= faultNext;
      misalignWarn <= resvNext;
      rangeErr     <= ctl.rangeBad;
    end
  end

  // R2: outputs hold without a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(baseAddr) && $stable(sizeFault)
                   && $stable(misalignWarn) && $stable(rangeErr)));
  // R3: plain layout keeps the top nibble clear
  a_r3_plain_hi: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.wide) |=> (baseAddr[PA_W-1:OA_W] == '0));
  // R5: wide layout never sets bits below the floor
  a_r5_wide_floor: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.wide) |=> (baseAddr[Z_FLOOR-1:0] == '0));
  // R7: no fault when wide PAs are supported
  a_r7_sup_nofault: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && pa52Sup) |=> !sizeFault);
  // R11: a range error leaves a zero address and no warning
  a_r11_range_zero: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (baseAddr == '0 && !misalignWarn));
endmodule

// File: rtl/s2_base_former.sv
module s2_base_former
  import s2base_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int PA_W    = 52,
  parameter int OA_W    = 48,
  parameter int X_W     = 6,
  parameter int PS_W    = 3,
  parameter int X_MIN   = 1,
  parameter int X_MAX   = 47,
  parameter int Z_FLOOR = 6,
  parameter int HI_LSB  = 2,
  parameter logic [PS_W-1:0] WIDE_PS = 3'b110
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REG_W-1:0] regVal,
  input  logic [PS_W-1:0]  psField,
  input  logic             gran64k,
  input  logic [X_W-1:0]   alignExp,
  input  logic             pa52Sup,
  output logic [PA_W-1:0]  baseAddr,
  output logic             sizeFault,
  output logic             misalignWarn,
  output logic             rangeErr
);
  ctlStrobes_t ctl;

  s2base_ctrl #(
    .X_W(X_W), .PS_W(PS_W), .X_MIN(X_MIN), .X_MAX(X_MAX), .WIDE_PS(WIDE_PS)
  ) uCtrl (
    .start(start), .psField(psField), .gran64k(gran64k),
    .alignExp(alignExp), .ctl(ctl)
  );

  s2base_dpath #(
    .REG_W(REG_W), .PA_W(PA_W), .OA_W(OA_W), .X_W(X_W),
    .Z_FLOOR(Z_FLOOR), .HI_LSB(HI_LSB)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regVal(regVal),
    .alignExp(alignExp), .pa52Sup(pa52Sup), .baseAddr(baseAddr),
    .sizeFault(sizeFault), .misalignWarn(misalignWarn), .rangeErr(rangeErr)
  );
endmodule

// File: tb/tb_s2_base_former.sv
module tb_s2_base_former;
  typedef struct packed {
    logic [63:0] r;
    logic [2:0]  ps;
    logic        g;
    logic [5:0]  x;
    logic        sup;
    logic [51:0] a;
    logic        f;
    logic        m;
    logic        e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{64'hAB00_1234_5678_9000, 3'b101, 1'b1, 6'd12, 1'b0, 52'h0_1234_5678_9000, 1'b0, 1'b0, 1'b0},
    '{64'h0000_0000_0001_0010, 3'b010, 1'b0, 6'd12, 1'b1, 52'h0_0000_0001_0000, 1'b0, 1'b1, 1'b0},
    '{64'h0000_0000_0000_1001, 3'b000, 1'b0, 6'd12, 1'b0, 52'h0_0000_0000_1000, 1'b0, 1'b0, 1'b0},
    '{64'h0000_00AB_CDEF_0014, 3'b110, 1'b1, 6'd16, 1'b1, 52'h5_00AB_CDEF_0000, 1'b0, 1'b0, 1'b0},
    '{64'h0000_00AB_CDEF_0014, 3'b110, 1'b1, 6'd16, 1'b0, 52'h5_00AB_CDEF_0000, 1'b1, 1'b0, 1'b0},
    '{64'h0000_0000_1234_56FC, 3'b110, 1'b1, 6'd4,  1'b1, 52'hF_0000_1234_56C0, 1'b0, 1'b0, 1'b0},
    '{64'h0000_0000_0000_0142, 3'b110, 1'b1, 6'd10, 1'b0, 52'h0_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'h0000_0000_0000_303C, 3'b110, 1'b0, 6'd12, 1'b0, 52'h0_0000_0000_3000, 1'b0, 1'b1, 1'b0},
    '{64'h0000_0000_0000_F0F4, 3'b110, 1'b1, 6'd0,  1'b0, 52'h0_0000_0000_0000, 1'b1, 1'b0, 1'b1},
    '{64'h0000_0000_1234_5678, 3'b001, 1'b0, 6'd48, 1'b0, 52'h0_0000_0000_0000, 1'b0, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 3'b010, 1'b0, 6'd47, 1'b1, 52'h0_8000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0003, 3'b000, 1'b0, 6'd1,  1'b0, 52'h0_0000_0000_0002, 1'b0, 1'b0, 1'b0},
    '{64'h0000_0000_0000_0042, 3'b110, 1'b1, 6'd6,  1'b1, 52'h0_0000_0000_0040, 1'b0, 1'b1, 1'b0}
  };

  function automatic string tagOf(input int i);
    case (i)
      0: return "R3 R10";  1: return "R3 R8";   2: return "R8 R10";
      3: return "R4 R7";   4: return "R6 R4";   5: return "R5";
      6: return "R9";      7: return "R12 R8";  8: return "R11 R6";
      9: return "R11";     10: return "R3 R8";  11: return "R3 R8";
      default: return "R9 R4";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] regVal = '0;
  logic [2:0]  psField = '0;
  logic        gran64k = 1'b0;
  logic [5:0]  alignExp = 6'd12;
  logic        pa52Sup = 1'b0;
  logic [51:0] baseAddr;
  logic        sizeFault, misalignWarn, rangeErr;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  s2_base_former dut (
    .clk(clk), .rstN(rstN), .start(start), .regVal(regVal),
    .psField(psField), .gran64k(gran64k), .alignExp(alignExp),
    .pa52Sup(pa52Sup), .baseAddr(baseAddr), .sizeFault(sizeFault),
    .misalignWarn(misalignWarn), .rangeErr(rangeErr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [51:0] act, input logic [51:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input vec_t v);
    chk(tag, "baseAddr", baseAddr, v.a);
    chk(tag, "sizeFault", 52'(sizeFault), 52'(v.f));
    chk(tag, "misalignWarn", 52'(misalignWarn), 52'(v.m));
    chk(tag, "rangeErr", 52'(rangeErr), 52'(v.e));
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    regVal = v.r; psField = v.ps; gran64k = v.g;
    alignExp = v.x; pa52Sup = v.sup; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    vec_t zeroV;
    zeroV = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", zeroV);  // R1: reset state

    for (int i = 0; i < NV; i++) begin
      applyVec(VECS[i]);
      checkAll(tagOf(i), VECS[i]);
    end

    // R2: change every input without a strobe; the last result must hold
    @(negedge clk);
    regVal = 64'h0000_7777_0000_003C; psField = 3'b110; gran64k = 1'b1;
    alignExp = 6'd0; pa52Sup = 1'b0;
    repeat (4) @(negedge clk);
    checkAll("R2", VECS[NV-1]);

    // R10: bit 0 and the top field alone differ from vector 0
    begin
      vec_t v;
      v = VECS[0];
      v.r = 64'h5500_1234_5678_9001;
      applyVec(v);
      checkAll("R10", v);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule